// File: doc/BRIEF.md
# MDIO Station Management Controller

This controller carries out management reads and writes to an external Ethernet PHY over the two-wire MDC/MDIO management bus. Software sets it up through two registers. The command register takes the PHY address, the register address, a direction select and a clock-range code, and it is written together with a start flag. The data register holds the 16-bit value to send on a write, and on a read it receives the value that the PHY returns.

Writing the command with the start flag set raises busy. The controller then derives MDC from the system clock, using a divider chosen by the range code, and shifts one complete management frame out on MDIO. For the read-back part of a read frame it releases the line and captures the bits the PHY drives. Busy drops when the frame ends, and software polls busy to learn that the operation is over.

Top module: `mdio_mgmt`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `busy` is 0, `mdc` is 0, `mdio_oe` is 0 and `dat_rdata` is 0.
- R2: When `busy` is 0, a clock edge with `cmd_we`=1 and `cmd_go`=1 accepts the command. `busy` reads 1 from the next cycle on. A `cmd_we` with `cmd_go`=0 starts nothing.
- R3: `cmd_range` selects the MDC period in system clocks: 0→42, 1→62, 2→16, 3→26, and 4 to 7→102. Each MDC period spends its first half low and its second half high.
- R4: A frame is 64 MDC periods, one bit per period, sent MSB first. It has 32 ones, then 01, then the opcode (10 for a read, when `cmd_write`=0; 01 for a write), the 5-bit PHY address, the 5-bit register address, 2 turnaround bits and 16 data bits.
- R5: In a write frame, `mdio_oe` stays 1 for the whole frame. The turnaround is driven as 1 then 0, and the data bits come from the data register.
- R6: In a read frame, `mdio_oe` is 0 from the first turnaround bit to the end of the frame. Each data bit is sampled from `mdio_i` at the clock edge where MDC rises. The 16 bits replace the data register when the frame ends.
- R7: `mdio_o` changes only at the start of a bit period, which is the point where MDC falls or a frame begins.
- R8: `busy` stays 1 for exactly 64 MDC periods (64 × divisor cycles) after acceptance, then returns to 0.
- R9: Command writes made while `busy` is 1 are ignored. This includes the last busy cycle: the frame in progress is unchanged and no new frame starts.
- R10: Data register writes made while `busy` is 1 are ignored.
- R11: While `busy` is 0, `mdc` is held low and MDIO is released (`mdio_oe`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_phy | input | 5 | PHY address field |
| cmd_reg | input | 5 | PHY register address field |
| cmd_write | input | 1 | 1 = write frame, 0 = read frame |
| cmd_range | input | 3 | System clock range code selecting the MDC divider |
| cmd_go | input | 1 | Start flag (busy bit as written) |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 16 | Data register write value |
| busy | output | 1 | Operation in progress |
| dat_rdata | output | 16 | Data register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest situation to reach from the ports is a command write that lands on the very cycle in which busy falls. That write must be ignored, and the next edge must then start a fresh frame. The bench reaches it without tracking time by holding the command strobe and start flag high across the whole tail of a frame. This forces a write onto every edge, including the final busy one, and the model then expects the back-to-back frame one cycle later. A PHY model answers read frames bit by bit. It also writes the data register while a frame is under way, so that the ignored update would show on `dat_rdata`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DAT_W  = 16;
    localparam int RNG_W  = 3;
    localparam int HDR_W  = 2 + 2 + PHY_W + REG_W + 2;

    // Half of the MDC period, in system clocks, for each range code.
    function automatic logic [7:0] half_period(input logic [RNG_W-1:0] code);
        case (code)
            3'd0:    half_period = 8'd21;   // 60..100 MHz, /42
            3'd1:    half_period = 8'd31;   // 100..150 MHz, /62
            3'd2:    half_period = 8'd8;    // 20..35 MHz, /16
            3'd3:    half_period = 8'd13;   // 35..60 MHz, /26
            default: half_period = 8'd51;   // 150 MHz and up, /102
        endcase
    endfunction

endpackage

// File: rtl/mdio_div.sv
module mdio_div
    import mdio_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [RNG_W-1:0] rng,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_s;

    div_s q, d;
    logic [CNT_W-1:0] lim;
    logic             last;

    always_comb begin
        lim  = CNT_W'(half_period(rng) - 8'd1);
        last = (q.cnt == lim);
        d    = q;
        if (!run) begin
            d = '0;
        end else if (last) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        rise = run & last & ~q.mdc;
        fall = run & last & q.mdc;
        mdc  = q.mdc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_DIV_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc && (q.cnt == '0)); // R11

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int FRAME_LEN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic                 rd,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 done,
    output logic [DAT_W-1:0]     rdata
);
    localparam int BIT_W     = $clog2(FRAME_LEN);
    localparam int DAT_START = FRAME_LEN - DAT_W;
    localparam int TA_START  = DAT_START - 2;
    localparam int LAST_BIT  = FRAME_LEN - 1;

    typedef struct packed {
        logic [FRAME_LEN-1:0] sh;
        logic [BIT_W-1:0]     bitn;
        logic [DAT_W-1:0]     rsh;
        logic                 active;
        logic                 rd;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (start) begin
            d.sh     = frame;
            d.bitn   = '0;
            d.active = 1'b1;
            d.rd     = rd;
        end else if (q.active) begin
            if (rise && q.rd && (q.bitn >= BIT_W'(DAT_START)))
                d.rsh = {q.rsh[DAT_W-2:0], mdio_i};
            if (fall) begin
                if (q.bitn == BIT_W'(LAST_BIT)) begin
                    d.active = 1'b0;
                    done     = 1'b1;
                end else begin
                    d.bitn = q.bitn + 1'b1;
                    d.sh   = {q.sh[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
        mdio_o  = q.sh[FRAME_LEN-1];
        mdio_oe = q.active & ~(q.rd & (q.bitn >= BIT_W'(TA_START)));
        rdata   = q.rsh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        q.active && !fall && !start |=> $stable(mdio_o)); // R7

endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [PHY_W-1:0] cmd_phy,
    input  logic [REG_W-1:0] cmd_reg,
    input  logic             cmd_write,
    input  logic [RNG_W-1:0] cmd_range,
    input  logic             cmd_go,
    input  logic             dat_we,
    input  logic [DAT_W-1:0] dat_wdata,
    output logic             busy,
    output logic [DAT_W-1:0] dat_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam int FRAME_LEN = PRE_BITS + HDR_W + DAT_W;

    typedef struct packed {
        logic             busy;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regad;
        logic             wr;
        logic [RNG_W-1:0] rng;
        logic [DAT_W-1:0] data;
    } top_s;

    top_s q, d;
    logic                 accept;
    logic [FRAME_LEN-1:0] frame;
    logic                 rise, fall, seq_done;
    logic [DAT_W-1:0]     seq_rdata;

    always_comb begin
        accept = cmd_we & cmd_go & ~q.busy;
        d      = q;
        if (dat_we && !q.busy) d.data = dat_wdata;
        if (accept) begin
            d.busy  = 1'b1;
            d.phy   = cmd_phy;
            d.regad = cmd_reg;
            d.wr    = cmd_write;
            d.rng   = cmd_range;
        end
        if (seq_done) begin
            d.busy = 1'b0;
            if (!q.wr) d.data = seq_rdata;
        end
        frame = {{PRE_BITS{1'b1}}, 2'b01, (d.wr ? 2'b01 : 2'b10),
                 d.phy, d.regad, 2'b10, d.data};
        busy      = q.busy;
        dat_rdata = q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    mdio_div #(.CNT_W(CNT_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.busy),
        .rng  (q.rng),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .frame  (frame),
        .rd     (~cmd_write),
        .rise   (rise),
        .fall   (fall),
        .mdio_i (mdio_i),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .done   (seq_done),
        .rdata  (seq_rdata)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !mdc && !mdio_oe); // R11

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && cmd_we |=> $stable({q.phy, q.regad, q.wr, q.rng})); // R9

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && dat_we && !seq_done |=> $stable(q.data)); // R10

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> q.busy && mdc); // R8

endmodule

// File: tb/sim_mdio_mgmt.sv
module sim_mdio_mgmt;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0, cmd_write = 1'b0, cmd_go = 1'b0, dat_we = 1'b0;
    logic [4:0]  cmd_phy = '0, cmd_reg = '0;
    logic [2:0]  cmd_range = '0;
    logic [15:0] dat_wdata = '0;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    logic [15:0] dat_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural model state
    bit          m_busy = 0;
    bit          m_rd   = 0;
    int          m_k    = 0;
    int          m_div  = 16;
    logic [63:0] m_frame = '0;
    logic [15:0] m_data  = '0;
    logic [15:0] phy_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_phy(cmd_phy),
        .cmd_reg(cmd_reg), .cmd_write(cmd_write), .cmd_range(cmd_range),
        .cmd_go(cmd_go), .dat_we(dat_we), .dat_wdata(dat_wdata),
        .busy(busy), .dat_rdata(dat_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    function automatic int div_of(input logic [2:0] code);
        case (code)
            3'd0: return 42;
            3'd1: return 62;
            3'd2: return 16;
            3'd3: return 26;
            default: return 102;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_data = '0;
        end else if (m_busy) begin
            m_k++;
            if (m_k == FRAME * m_div) begin
                m_busy = 0;
                if (m_rd) m_data = phy_val;
            end
        end else begin
            if (dat_we) m_data = dat_wdata;
            if (cmd_we && cmd_go) begin
                m_busy  = 1;
                m_k     = 0;
                m_div   = div_of(cmd_range);
                m_rd    = !cmd_write;
                m_frame = {32'hFFFF_FFFF, 2'b01, (cmd_write ? 2'b01 : 2'b10),
                           cmd_phy, cmd_reg, 2'b10, m_data};
            end
        end
    end

    // compare every clock, and play the PHY
    always @(negedge clk) begin
        int bitn;
        bitn = m_k / m_div;
        if (rst_n) begin
            chk("R8 busy", 64'(busy), 64'(m_busy));
            chk("R10 data", 64'(dat_rdata), 64'(m_data));
            if (m_busy) begin
                chk("R3 mdc", 64'(mdc), 64'((m_k % m_div) >= (m_div / 2)));
                chk("R5 R6 oe", 64'(mdio_oe), 64'(!(m_rd && bitn >= 46)));
                if (mdio_oe)
                    chk("R4 R5 R7 mdio_o", 64'(mdio_o), 64'(m_frame[63 - bitn]));
            end else begin
                chk("R11 idle mdc", 64'(mdc), 64'd0);
                chk("R11 idle oe", 64'(mdio_oe), 64'd0);
            end
        end
        mdio_i = (m_busy && m_rd && bitn >= 48) ? phy_val[63 - bitn] : 1'b1;
    end

    task automatic issue(input logic [4:0] phy, input logic [4:0] rg,
                         input logic wr, input logic [2:0] rng);
        @(negedge clk);
        cmd_we = 1; cmd_go = 1; cmd_phy = phy; cmd_reg = rg;
        cmd_write = wr; cmd_range = rng;
        @(negedge clk);
        cmd_we = 0; cmd_go = 0;
        #1;
        chk("R2 busy after accept", 64'(busy), 64'd1);
    endtask

    task automatic load_data(input logic [15:0] v);
        @(negedge clk);
        dat_we = 1; dat_wdata = v;
        @(negedge clk);
        dat_we = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 mdc", 64'(mdc), 64'd0);
        chk("R1 oe", 64'(mdio_oe), 64'd0);
        chk("R1 data", 64'(dat_rdata), 64'd0);
        rst_n = 1;
        @(negedge clk);
        #1;
        chk("R1 after release", 64'({busy, mdc, mdio_oe}), 64'd0);

        // start flag clear: nothing happens (R2)
        @(negedge clk);
        cmd_we = 1; cmd_go = 0; cmd_range = 3'd2;
        @(negedge clk);
        cmd_we = 0;
        #1;
        chk("R2 no go", 64'(busy), 64'd0);

        // write frame, /16, with ignored writes mid-frame (R5, R9, R10)
        load_data(16'hA5C3);
        issue(5'h13, 5'h0A, 1'b1, 3'd2);
        repeat (200) @(negedge clk);
        cmd_we = 1; cmd_go = 1; cmd_phy = 5'h1F; cmd_reg = 5'h01; cmd_write = 0; cmd_range = 3'd4;
        dat_we = 1; dat_wdata = 16'h0BAD;
        @(negedge clk);
        cmd_we = 0; cmd_go = 0; dat_we = 0;
        wait_idle();
        chk("R10 data kept", 64'(dat_rdata), 64'hA5C3);

        // read frame, /42 (R6)
        phy_val = 16'h3C96;
        issue(5'h01, 5'h02, 1'b0, 3'd0);
        wait_idle();
        chk("R6 read result", 64'(dat_rdata), 64'h3C96);

        // write /26, read /62
        load_data(16'h0001);
        issue(5'h0F, 5'h10, 1'b1, 3'd3);
        wait_idle();
        phy_val = 16'h8001;
        issue(5'h15, 5'h1F, 1'b0, 3'd1);
        wait_idle();
        chk("R6 read edge bits", 64'(dat_rdata), 64'h8001);

        // read with code 4, write with code 7 (both /102, R3)
        phy_val = 16'hFFFE;
        issue(5'h00, 5'h00, 1'b0, 3'd4);
        wait_idle();
        chk("R6 read code4", 64'(dat_rdata), 64'hFFFE);
        load_data(16'hFFFF);
        issue(5'h1F, 5'h1F, 1'b1, 3'd7);
        wait_idle();

        // hold command high over the end of a frame (R9)
        load_data(16'h1234);
        issue(5'h0A, 5'h05, 1'b1, 3'd2);
        repeat (900) @(negedge clk);
        cmd_we = 1; cmd_go = 1; cmd_phy = 5'h11; cmd_reg = 5'h06; cmd_write = 1; cmd_range = 3'd2;
        while (busy) @(negedge clk);
        @(negedge clk);
        cmd_we = 0; cmd_go = 0;
        #1;
        chk("R9 restart after end", 64'(busy), 64'd1);
        wait_idle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule